// File: doc/BRIEF.md
# Linked-List Sprite Line Evaluator

This block prepares sprite pixels for one display line at a time. When a line begins, it walks a sprite attribute table. The walk does not scan the table in index order. It starts at entry 0 and follows the link field that each entry carries. Every sprite whose vertical span includes the line goes into a small per-line buffer. The walk stops at the end of the chain, or when a sprite-count limit or a tile-count limit is reached.

Once the walk has finished (`busy` low), a pixel request with an x position scans the buffered sprites in the order they were collected. The block fetches pattern words as it goes and returns the colour and priority of the first sprite that has an opaque pixel at that position. Mixing the result with background layers is the job of downstream logic.

The attribute table and pattern memory are read combinationally: the address goes out and the data comes back in the same cycle. Each attribute entry is 64 bits wide. The walk visits one entry per cycle, and a pixel scan examines one buffered sprite per cycle.

Top module: `spr_line_eval`

## Requirements
- R1: The walk starts at entry 0 and then moves to the entry named by the current entry's link field, which sits in bits 22:16 of the 64-bit entry. It stops after an entry whose link is 0 or is at least NUM_ENTRIES (80). It also stops once NUM_ENTRIES entries have been visited, so a looping chain still ends. Entries that are not on the chain are never shown.
- R2: At most MAX_SPR (20) sprites are collected per line. Later sprites on the chain are never shown.
- R3: Each collected sprite adds its width in 8-pixel tiles to a running total. Collection stops once that total reaches MAX_TILES (40). The sprite that reaches the limit is kept.
- R4: A sprite covers line L when L+128 ≥ y and L+128 < y + height. Here y is entry bits 9:0, and height is (1 + bits 25:24) × 8 pixels.
- R5: A sprite that covers the line and has x equal to 0 ends collection without being shown. A sprite with x equal to 0 that does not cover the line has no effect.
- R6: A sprite covers pixel X when X+128 ≥ x and X+128 < x + width. Here x is entry bits 56:48, and width is (1 + bits 27:26) × 8 pixels.
- R7: Within a sprite, the tile number is column-major: tileX × (height/8) + tileY.
  - The word address is base×16 + tile×16 + row×2 + (column ≥ 4), taken modulo 2^15. Base is entry bits 42:32.
  - Row and column are the pixel's position inside the tile.
  - Each pattern word holds four 4-bit pixels, with the leftmost pixel in bits 15:12.
- R8: Buffered sprites are tested in the order they were collected. The first one with a nonzero pixel wins.
  - The colour output is palette×16 + pixel, where palette is entry bits 46:45.
  - The priority output is entry bit 47.
- R9: A pixel covered by no opaque sprite returns colour 0 with priority 0.
- R10: A line-start strobe clears the buffer and cancels any pixel scan in progress; no result is produced for the cancelled scan. A pixel request is ignored in the cycle of a line-start strobe and while `busy` is high.
- R11: After reset, `busy`, `pix_valid`, `pix_color` and `pix_pri` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle strobe that begins a new line |
| line_num | input | 9 | Line number, sampled with the strobe |
| sat_idx | output | 7 | Attribute table entry index |
| sat_word | input | 64 | Attribute table entry data, same cycle |
| busy | output | 1 | Line walk in progress |
| pix_req | input | 1 | One-cycle pixel request |
| pix_x | input | 9 | Pixel x position, sampled with the request |
| pat_addr | output | 15 | Pattern memory word address |
| pat_word | input | 16 | Pattern memory data, same cycle |
| pix_valid | output | 1 | One-cycle pulse marking a pixel result |
| pix_color | output | 6 | Palette and colour index of the result |
| pix_pri | output | 1 | Priority bit of the result |

## Verification
Two events can land in the same cycle: a line-start strobe and a pixel request. A line-start strobe can also arrive while a pixel scan is still running through the buffer. The bench provokes three such cases:
- a pixel scan that will take many cycles is cancelled by a new line start;
- a request is raised in the very cycle of the strobe;
- another request is raised while the walk is busy.

For each case, the bench judges that no `pix_valid` pulse appears. It then checks that the next requested pixels match its model of the new line.

// File: rtl/spr_eval_pkg.sv
package spr_eval_pkg;

    localparam int COORD_OFS = 128;
    localparam int LINK_W    = 7;

    // One collected sprite as held in the per-line buffer.
    typedef struct packed {
        logic [8:0]  xpos;
        logic [9:0]  ypos;
        logic [1:0]  wcode;
        logic [1:0]  hcode;
        logic        pri;
        logic [1:0]  pal;
        logic [10:0] base;
    } spr_slot_t;

    function automatic logic [LINK_W-1:0] ent_link(input logic [63:0] e);
        return e[22:16];
    endfunction

    function automatic logic [9:0] ent_y(input logic [63:0] e);
        return e[9:0];
    endfunction

    function automatic logic [8:0] ent_x(input logic [63:0] e);
        return e[56:48];
    endfunction

    function automatic logic [1:0] ent_hcode(input logic [63:0] e);
        return e[25:24];
    endfunction

    function automatic logic [1:0] ent_wcode(input logic [63:0] e);
        return e[27:26];
    endfunction

    function automatic spr_slot_t ent_slot(input logic [63:0] e);
        spr_slot_t s;
        s.xpos  = e[56:48];
        s.ypos  = e[9:0];
        s.wcode = e[27:26];
        s.hcode = e[25:24];
        s.pri   = e[47];
        s.pal   = e[46:45];
        s.base  = e[42:32];
        return s;
    endfunction

    // Half-open span test: start <= pos < start + (code+1)*8.
    function automatic logic spans(input logic [10:0] pos, input logic [10:0] start,
                                   input logic [1:0] code);
        logic [11:0] lim;
        lim = {1'b0, start} + {6'd0, ({1'b0, code} + 3'd1), 3'b000};
        return (pos >= start) && ({1'b0, pos} < lim);
    endfunction

endpackage

// File: rtl/spr_line_collect.sv
module spr_line_collect
    import spr_eval_pkg::*;
#(
    parameter int NUM_ENTRIES = 80,
    parameter int MAX_SPR     = 20,
    parameter int MAX_TILES   = 40,
    localparam int CNT_W  = $clog2(MAX_SPR + 1),
    localparam int TILE_W = $clog2(MAX_TILES + 5),
    localparam int VIS_W  = $clog2(NUM_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic [8:0]        line_num,
    output logic [LINK_W-1:0] sat_idx,
    input  logic [63:0]       sat_word,
    output logic              walking,
    output logic [8:0]        line_q,
    output logic [CNT_W-1:0]  cnt,
    output spr_slot_t         slots [MAX_SPR]
);

    logic [LINK_W-1:0] cur;
    logic [TILE_W-1:0] tiles;
    logic [VIS_W-1:0]  visits;

    logic [10:0]       line_pos;
    logic              covers, x_zero, take, keep_going;
    logic [CNT_W-1:0]  cnt_n;
    logic [TILE_W-1:0] tiles_n;
    logic [LINK_W-1:0] lnk;

    assign sat_idx = cur;

    always_comb begin
        line_pos = {2'b00, line_q} + 11'(COORD_OFS);
        covers   = spans(line_pos, {1'b0, ent_y(sat_word)}, ent_hcode(sat_word));
        x_zero   = (ent_x(sat_word) == 9'd0);
        take     = covers && !x_zero;
        cnt_n    = cnt + CNT_W'(take);
        tiles_n  = tiles + (take ? (TILE_W'(ent_wcode(sat_word)) + TILE_W'(1)) : TILE_W'(0));
        lnk      = ent_link(sat_word);
        keep_going = !(covers && x_zero)
                     && (lnk != '0)
                     && (32'(lnk) < NUM_ENTRIES)
                     && (32'(cnt_n) < MAX_SPR)
                     && (32'(tiles_n) < MAX_TILES)
                     && (32'(visits) + 1 < NUM_ENTRIES);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            walking <= 1'b0;
            cnt     <= '0;
            tiles   <= '0;
            cur     <= '0;
            visits  <= '0;
            line_q  <= '0;
        end else if (line_start) begin
            walking <= 1'b1;
            cnt     <= '0;
            tiles   <= '0;
            cur     <= '0;
            visits  <= '0;
            line_q  <= line_num;
        end else if (walking) begin
            cnt     <= cnt_n;
            tiles   <= tiles_n;
            cur     <= lnk;
            visits  <= visits + VIS_W'(1);
            walking <= keep_going;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_SPR; i++) begin
            if (!line_start && walking && take && (cnt == CNT_W'(i)))
                slots[i] <= ent_slot(sat_word);
        end
    end

    assert_walk_count_R2: assert property (@(posedge clk) disable iff (rst)
        walking |-> (32'(cnt) < MAX_SPR));

    assert_walk_tiles_R3: assert property (@(posedge clk) disable iff (rst)
        walking |-> (32'(tiles) < MAX_TILES));

    assert_walk_index_R1: assert property (@(posedge clk) disable iff (rst)
        walking |-> (32'(cur) < NUM_ENTRIES));

    assert_walk_bounded_R1: assert property (@(posedge clk) disable iff (rst)
        walking |-> (32'(visits) < NUM_ENTRIES));

endmodule

// File: rtl/spr_pixel_scan.sv
module spr_pixel_scan
    import spr_eval_pkg::*;
#(
    parameter int MAX_SPR = 20,
    parameter int ADDR_W  = 15,
    localparam int CNT_W  = $clog2(MAX_SPR + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              allow,
    input  logic              pix_req,
    input  logic [8:0]        pix_x,
    input  logic [8:0]        line_q,
    input  logic [CNT_W-1:0]  cnt,
    input  spr_slot_t         slots [MAX_SPR],
    output logic [ADDR_W-1:0] pat_addr,
    input  logic [15:0]       pat_word,
    output logic              pix_valid,
    output logic [5:0]        pix_color,
    output logic              pix_pri
);

    logic             scanning;
    logic [CNT_W-1:0] idx;
    logic [8:0]       x_q;

    spr_slot_t   sel;
    logic        end_list, hx, hit;
    logic [10:0] xpos, ypos, ox, oy;
    logic [3:0]  tilen, nib;

    always_comb begin
        end_list = !(idx < cnt);
        sel      = slots[end_list ? '0 : idx];
        xpos     = {2'b00, x_q} + 11'(COORD_OFS);
        ypos     = {2'b00, line_q} + 11'(COORD_OFS);
        hx       = spans(xpos, {2'b00, sel.xpos}, sel.wcode);
        ox       = xpos - {2'b00, sel.xpos};
        oy       = ypos - {1'b0, sel.ypos};
        // column-major tile order inside the sprite
        tilen    = {2'b00, ox[4:3]} * ({2'b00, sel.hcode} + 4'd1) + {2'b00, oy[4:3]};
        pat_addr = ADDR_W'({sel.base, 4'b0000}) + ADDR_W'({tilen, 4'b0000})
                 + ADDR_W'({oy[2:0], 1'b0}) + ADDR_W'(ox[2]);
        case (ox[1:0])
            2'd0:    nib = pat_word[15:12];
            2'd1:    nib = pat_word[11:8];
            2'd2:    nib = pat_word[7:4];
            default: nib = pat_word[3:0];
        endcase
        hit = !end_list && hx && (nib != 4'd0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scanning  <= 1'b0;
            idx       <= '0;
            x_q       <= '0;
            pix_valid <= 1'b0;
            pix_color <= '0;
            pix_pri   <= 1'b0;
        end else begin
            pix_valid <= 1'b0;
            if (abort) begin
                scanning <= 1'b0;
            end else if (scanning) begin
                if (end_list) begin
                    scanning  <= 1'b0;
                    pix_valid <= 1'b1;
                    pix_color <= '0;
                    pix_pri   <= 1'b0;
                end else if (hit) begin
                    scanning  <= 1'b0;
                    pix_valid <= 1'b1;
                    pix_color <= {sel.pal, nib};
                    pix_pri   <= sel.pri;
                end else begin
                    idx <= idx + CNT_W'(1);
                end
            end else if (pix_req && allow) begin
                scanning <= 1'b1;
                idx      <= '0;
                x_q      <= pix_x;
            end
        end
    end

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> !pix_valid);

    assert_clear_pixel_R9: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && (pix_color[3:0] == 4'd0)) |-> !pix_pri);

    assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        abort |=> !pix_valid);

endmodule

// File: rtl/spr_line_eval.sv
module spr_line_eval
    import spr_eval_pkg::*;
#(
    parameter int NUM_ENTRIES = 80,
    parameter int MAX_SPR     = 20,
    parameter int MAX_TILES   = 40,
    parameter int ADDR_W      = 15,
    localparam int CNT_W      = $clog2(MAX_SPR + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic [8:0]        line_num,
    output logic [6:0]        sat_idx,
    input  logic [63:0]       sat_word,
    output logic              busy,
    input  logic              pix_req,
    input  logic [8:0]        pix_x,
    output logic [ADDR_W-1:0] pat_addr,
    input  logic [15:0]       pat_word,
    output logic              pix_valid,
    output logic [5:0]        pix_color,
    output logic              pix_pri
);

    logic             walking;
    logic [8:0]       line_q;
    logic [CNT_W-1:0] cnt;
    spr_slot_t        slots [MAX_SPR];

    spr_line_collect #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .MAX_SPR    (MAX_SPR),
        .MAX_TILES  (MAX_TILES)
    ) i_collect (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .line_num  (line_num),
        .sat_idx   (sat_idx),
        .sat_word  (sat_word),
        .walking   (walking),
        .line_q    (line_q),
        .cnt       (cnt),
        .slots     (slots)
    );

    spr_pixel_scan #(
        .MAX_SPR(MAX_SPR),
        .ADDR_W (ADDR_W)
    ) i_scan (
        .clk      (clk),
        .rst      (rst),
        .abort    (line_start),
        .allow    (!walking),
        .pix_req  (pix_req),
        .pix_x    (pix_x),
        .line_q   (line_q),
        .cnt      (cnt),
        .slots    (slots),
        .pat_addr (pat_addr),
        .pat_word (pat_word),
        .pix_valid(pix_valid),
        .pix_color(pix_color),
        .pix_pri  (pix_pri)
    );

    assign busy = walking;

endmodule

// File: tb/test_spr_line_eval.sv
module test_spr_line_eval;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_start = 1'b0;
    logic [8:0]  line_num = '0;
    logic [6:0]  sat_idx;
    logic [63:0] sat_word;
    logic        busy;
    logic        pix_req = 1'b0;
    logic [8:0]  pix_x = '0;
    logic [14:0] pat_addr;
    logic [15:0] pat_word;
    logic        pix_valid;
    logic [5:0]  pix_color;
    logic        pix_pri;

    int total = 0;
    int bad   = 0;

    logic [63:0] sat_mem [128];

    always #10 clk = ~clk;

    function automatic logic [15:0] pat_fn(input int a);
        if ((a & 16384) != 0) return 16'h0000;
        return 16'((a * 12085 + 27) & 65535);
    endfunction

    assign sat_word = sat_mem[sat_idx];
    assign pat_word = pat_fn(int'(pat_addr));

    spr_line_eval i_spr_line_eval (
        .clk(clk), .rst(rst), .line_start(line_start), .line_num(line_num),
        .sat_idx(sat_idx), .sat_word(sat_word), .busy(busy),
        .pix_req(pix_req), .pix_x(pix_x), .pat_addr(pat_addr), .pat_word(pat_word),
        .pix_valid(pix_valid), .pix_color(pix_color), .pix_pri(pix_pri)
    );

    // ---------------- reference model ----------------
    int rn;
    int rx [20], ry [20], rw [20], rh [20], rpal [20], rpri [20], rbase [20];

    function automatic logic [63:0] mk(int x, int y, int wc, int hc, int link,
                                       int pri, int pal, int base);
        logic [63:0] e = '0;
        e[9:0]   = 10'(y);
        e[22:16] = 7'(link);
        e[25:24] = 2'(hc);
        e[27:26] = 2'(wc);
        e[47]    = 1'(pri);
        e[46:45] = 2'(pal);
        e[42:32] = 11'(base);
        e[56:48] = 9'(x);
        return e;
    endfunction

    task automatic clear_table();
        for (int i = 0; i < 128; i++) sat_mem[i] = '0;
    endtask

    task automatic ref_collect(input int line);
        int cur = 0, tiles = 0, visits = 0, pos, y, h, x, lk;
        bit done = 0;
        logic [63:0] e;
        rn = 0;
        pos = line + 128;
        while (!done) begin
            e  = sat_mem[cur];
            y  = int'(e[9:0]);
            h  = (int'(e[25:24]) + 1) * 8;
            x  = int'(e[56:48]);
            lk = int'(e[22:16]);
            if (pos >= y && pos < y + h && x == 0) begin
                done = 1;
            end else begin
                if (pos >= y && pos < y + h) begin
                    rx[rn] = x; ry[rn] = y; rh[rn] = h;
                    rw[rn] = (int'(e[27:26]) + 1) * 8;
                    rpal[rn] = int'(e[46:45]); rpri[rn] = int'(e[47]);
                    rbase[rn] = int'(e[42:32]);
                    tiles += rw[rn] / 8;
                    rn++;
                end
                visits++;
                cur = lk;
                if (lk == 0 || lk >= 80 || rn >= 20 || tiles >= 40 || visits >= 80) done = 1;
            end
        end
    endtask

    function automatic int ref_pixel(input int line, input int px);
        int xp = px + 128, ox, oy, tile, addr, nib;
        for (int i = 0; i < rn; i++) begin
            if (xp >= rx[i] && xp < rx[i] + rw[i]) begin
                ox = xp - rx[i];
                oy = line + 128 - ry[i];
                tile = (ox / 8) * (rh[i] / 8) + (oy / 8);
                addr = (rbase[i] * 16 + tile * 16 + (oy % 8) * 2 + (ox % 8) / 4) & 32767;
                nib = (int'(pat_fn(addr)) >> (4 * (3 - (ox % 4)))) & 15;
                if (nib != 0) return rpri[i] * 64 + rpal[i] * 16 + nib;
            end
        end
        return 0;
    endfunction

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_line(input int line);
        int g = 0;
        @(negedge clk);
        line_start = 1'b1;
        line_num = 9'(line);
        @(negedge clk);
        line_start = 1'b0;
        while (busy && g < 200) begin
            @(negedge clk);
            g++;
        end
        chk("R1 walk terminates", int'(busy), 0);
    endtask

    task automatic do_pixel(input int px, output int v);
        int g = 0;
        @(negedge clk);
        pix_req = 1'b1;
        pix_x = 9'(px);
        @(negedge clk);
        pix_req = 1'b0;
        while (!pix_valid && g < 100) begin
            @(negedge clk);
            g++;
        end
        v = pix_valid ? int'(pix_pri) * 64 + int'(pix_color) : -1;
    endtask

    task automatic sweep(input string tag, input int line, input int x0, input int x1);
        int v;
        do_line(line);
        ref_collect(line);
        for (int x = x0; x <= x1; x++) begin
            do_pixel(x, v);
            chk(tag, v, ref_pixel(line, x));
        end
    endtask

    task automatic expect_px(input string tag, input int px, input int exp);
        int v;
        do_pixel(px, v);
        chk(tag, v, exp);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int seen;
        clear_table();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", int'(busy), 0);
        chk("R11 pix_valid", int'(pix_valid), 0);
        chk("R11 pix_color", int'(pix_color), 0);
        chk("R11 pix_pri", int'(pix_pri), 0);

        // Scenario A: scattered chain, multi-tile sprites, a transparent sprite,
        // an off-chain sprite
        clear_table();
        sat_mem[0]  = mk(140, 130, 1, 2, 5, 1, 1, 16);
        sat_mem[5]  = mk(150, 128, 3, 1, 3, 0, 2, 64);
        sat_mem[3]  = mk(135, 140, 0, 0, 9, 1, 3, 1100);
        sat_mem[9]  = mk(130, 125, 2, 3, 0, 0, 0, 200);
        sat_mem[20] = mk(128, 128, 3, 3, 0, 1, 3, 300);
        sweep("R4/R6/R7/R8", 0, 0, 63);
        sweep("R4/R6/R7/R8", 3, 0, 63);
        sweep("R4/R6/R7/R8", 12, 0, 63);
        sweep("R4/R6/R7/R8", 15, 0, 63);
        sweep("R4/R6/R7/R8", 22, 0, 63);
        sweep("R4/R9", 29, 0, 63);

        // Scenario B: 25 single-tile sprites, only 20 may appear
        clear_table();
        for (int i = 0; i < 25; i++)
            sat_mem[i] = mk(128 + 8 * i, 128, 0, 0, (i == 24) ? 0 : i + 1, i & 1, i & 3, 10 + i);
        sweep("R2", 0, 0, 199);
        expect_px("R2 sprite 21 dropped", 163, 0);
        // a line no sprite covers: buffer must have been cleared
        sweep("R9/R10 cleared", 50, 0, 199);

        // Scenario C: four-tile sprites, tile limit 40 reached by the tenth
        clear_table();
        for (int i = 0; i < 12; i++)
            sat_mem[i] = mk(128 + 32 * i, 128, 3, 0, (i == 11) ? 0 : i + 1, 0, 1, 400 + i);
        sweep("R3", 0, 0, 383);
        expect_px("R3 sprite 11 dropped", 330, 0);

        // R10: line start cancels a long pixel scan; request in the strobe cycle
        @(negedge clk);
        pix_req = 1'b1;
        pix_x = 9'd380;
        @(negedge clk);
        pix_req = 1'b0;
        @(negedge clk);
        line_start = 1'b1;
        line_num = 9'd0;
        pix_req = 1'b1;
        pix_x = 9'd5;
        @(negedge clk);
        line_start = 1'b0;
        // request while busy
        pix_req = 1'b1;
        pix_x = 9'd6;
        chk("R10 busy after strobe", int'(busy), 1);
        @(negedge clk);
        pix_req = 1'b0;
        seen = 0;
        repeat (40) begin
            @(negedge clk);
            if (pix_valid) seen = 1;
        end
        chk("R10 no result after cancel", seen, 0);
        chk("R10 walk done", int'(busy), 0);
        ref_collect(0);
        for (int x = 0; x < 40; x++) begin
            int v;
            do_pixel(x * 9, v);
            chk("R10 after cancel", v, ref_pixel(0, x * 9));
        end

        // Scenario D: covering x==0 ends the walk, non-covering x==0 does not
        clear_table();
        sat_mem[0] = mk(0, 300, 0, 0, 1, 0, 1, 30);
        sat_mem[1] = mk(140, 128, 0, 0, 2, 1, 2, 31);
        sat_mem[2] = mk(0, 128, 0, 0, 3, 0, 3, 32);
        sat_mem[3] = mk(160, 128, 1, 0, 0, 0, 3, 33);
        sweep("R5", 0, 0, 63);
        expect_px("R5 after stop sprite", 33, 0);

        // Scenario E: link of 80 or more ends the walk
        clear_table();
        sat_mem[0]  = mk(140, 128, 0, 0, 85, 0, 1, 40);
        sat_mem[85] = mk(160, 128, 1, 0, 0, 1, 2, 41);
        sweep("R1", 0, 0, 63);
        expect_px("R1 link beyond table", 33, 0);

        // Scenario F: self loop on non-covering entries must still end
        clear_table();
        sat_mem[0] = mk(140, 400, 0, 0, 7, 0, 1, 50);
        sat_mem[7] = mk(140, 400, 0, 0, 7, 0, 1, 51);
        do_line(0);
        expect_px("R1/R9 looped chain", 13, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule